// File: doc/BRIEF.md
# Peripheral DMA Request Engine with End-of-Transfer Detection

This block is the peripheral side of a DMA handshake between a host DMA controller and a 16-bit word buffer. Once software sets the enable input, the engine raises a request line and waits. The host answers by asserting its acknowledge and, in the same cycle, giving one read or one write strobe. Each such cycle moves one 16-bit word, and the engine reports that move to the buffer on a one-cycle read or write pulse. Requests repeat, either one word at a time or in bursts of 4 or 8 words, until the transfer ends.

The transfer can end in two ways. The first is an external end-of-transfer line from the host. It passes through a two-flop synchroniser and counts only while the acknowledge is present. The second is an internal byte counter. It adds 2 for every accepted word, restarts at zero each time the enable is switched on, and, when counting is allowed, ends the transfer once it reaches the programmed byte count. After either kind of end, the request stays low and a done flag stays high until software drops the enable.

Top module: `dma_eot_engine`

## Requirements
- R1: During and directly after reset, `dreq`, `done`, `buf_rd` and `buf_wr` are all 0.
- R2: `dreq` goes to 1 on the clock edge after the edge that first samples `cfg_en` high. It then stays 1 while the host gives no valid word.
- R3: A word is accepted only when `dreq`, `dack` and exactly one of `rd_stb`/`wr_stb` are all 1. `buf_rd` or `buf_wr` pulses in that same cycle. A strobe without `dack`, both strobes together, or any strobe while `dreq` is 0 gives no pulse and is not counted.
- R4: With `cfg_burst`=0 (single mode), `dreq` is 0 for exactly one cycle after each accepted word that does not end the transfer, and then returns to 1.
- R5: With `cfg_burst`=1, a burst is 4 words when `cfg_burst8`=0 and 8 words when `cfg_burst8`=1. `dreq` stays 1 inside a burst and is 0 for exactly one cycle after the last word of a burst.
- R6: The internal count adds 2 bytes per accepted word. When `cfg_cnt_en`=1, the word that brings the count to `xfer_bytes` or above ends the transfer. On the next edge `done`=1 and `dreq`=0.
- R7: The byte count returns to zero each time `cfg_en` goes from 0 to 1. A new transfer therefore needs the full count again.
- R8: The external end signal `eot_in` acts only while `dack`=1. With `eot_in` and `dack` both held from one negative edge, `done` rises on the third positive edge after that negative edge.
- R9: After the transfer ends, `done` stays 1 and `dreq` stays 0 for as long as `cfg_en` stays 1.
- R10: With `cfg_cnt_en`=0, the byte count never ends the transfer.
- R11: When `cfg_en` is 0, `dreq` and `done` are 0 from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | DMA enable; a 0-to-1 change starts a transfer |
| cfg_cnt_en | input | 1 | Allows the internal byte count to end the transfer |
| cfg_burst | input | 1 | 0 = single-word requests, 1 = burst requests |
| cfg_burst8 | input | 1 | Burst length: 0 = 4 words, 1 = 8 words |
| xfer_bytes | input | 16 | Programmed transfer length in bytes |
| dack | input | 1 | Host DMA acknowledge |
| rd_stb | input | 1 | Host read strobe (buffer to host) |
| wr_stb | input | 1 | Host write strobe (host to buffer) |
| eot_in | input | 1 | External end of transfer, asynchronous |
| dreq | output | 1 | DMA request to the host |
| done | output | 1 | Transfer finished; held until the enable drops |
| buf_rd | output | 1 | One word is read from the buffer this cycle |
| buf_wr | output | 1 | One word is written into the buffer this cycle |

## Verification
A wrong byte count or a bad compare shows as `done` rising one or more words early or late. The sweep over every length from 1 to 20 bytes catches this on the first transfer where the error matters. A wrong beat counter shows as a missing or extra one-cycle gap in `dreq` inside the first burst. An extra or missing synchroniser stage moves the rise of `done` on the external-end path by one edge. A state that is not cleared on enable shows as an early end in the transfer that follows.

// File: rtl/dma_eot_pkg.sv
package dma_eot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2,
        ST_DONE = 2'd3
    } dma_state_e;

    localparam int unsigned BYTES_PER_WORD = 2;

endpackage

// File: rtl/dma_eot_sync.sv
module dma_eot_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] shift_q, shift_d;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb shift_d = {shift_q[STAGES-2:0], din};
        end else begin : g_single
            always_comb shift_d = din;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= shift_d;
    end

    assign dout = shift_q[STAGES-1];
endmodule

// File: rtl/dma_eot_bytecnt.sv
module dma_eot_bytecnt
    import dma_eot_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] limit,
    output logic             last_word
);
    localparam int unsigned ACC_W = CNT_W + 1;

    logic [ACC_W-1:0] count_q, count_d, count_nx;

    always_comb begin
        count_nx = count_q + ACC_W'(BYTES_PER_WORD);
        count_d  = count_q;
        if (clr)
            count_d = '0;
        else if (inc && !count_q[ACC_W-1])
            count_d = count_nx;
        last_word = cnt_en && (count_nx >= {1'b0, limit});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !count_q[ACC_W-1]) |=> (count_q == $past(count_q) + ACC_W'(BYTES_PER_WORD))); // R6

    AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0)); // R7
endmodule

// File: rtl/dma_eot_fsm.sv
module dma_eot_fsm
    import dma_eot_pkg::*;
#(
    parameter int unsigned BURST_SHORT = 4,
    parameter int unsigned BURST_LONG  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_en,
    input  logic cfg_burst,
    input  logic cfg_burst8,
    input  logic dack,
    input  logic rd_stb,
    input  logic wr_stb,
    input  logic eot_sync,
    input  logic last_word,
    output logic dreq,
    output logic done,
    output logic accept,
    output logic clr_cnt
);
    localparam int unsigned BEAT_W = (BURST_LONG > 1) ? $clog2(BURST_LONG) : 1;

    typedef struct packed {
        dma_state_e        state;
        logic              en;
        logic [BEAT_W-1:0] beat;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic ext_hit, en_rise, beat_last;
    logic [BEAT_W-1:0] beat_max;

    always_comb begin
        if (!cfg_burst)      beat_max = '0;
        else if (cfg_burst8) beat_max = BEAT_W'(BURST_LONG - 1);
        else                 beat_max = BEAT_W'(BURST_SHORT - 1);

        beat_last = (cur_q.beat == beat_max);
        accept    = (cur_q.state == ST_REQ) && dack && (rd_stb ^ wr_stb);
        ext_hit   = eot_sync && dack &&
                    ((cur_q.state == ST_REQ) || (cur_q.state == ST_GAP));
        en_rise   = cfg_en && !cur_q.en;
        clr_cnt   = en_rise;

        nxt_d    = cur_q;
        nxt_d.en = cfg_en;
        if (!cfg_en) begin
            nxt_d.state = ST_IDLE;
            nxt_d.beat  = '0;
        end else if (en_rise) begin
            nxt_d.state = ST_REQ;
            nxt_d.beat  = '0;
        end else begin
            unique case (cur_q.state)
                ST_REQ: begin
                    if (accept) begin
                        if (last_word || ext_hit) begin
                            nxt_d.state = ST_DONE;
                        end else if (beat_last) begin
                            nxt_d.state = ST_GAP;
                            nxt_d.beat  = '0;
                        end else begin
                            nxt_d.beat = cur_q.beat + 1'b1;
                        end
                    end else if (ext_hit) begin
                        nxt_d.state = ST_DONE;
                    end
                end
                ST_GAP:  nxt_d.state = ext_hit ? ST_DONE : ST_REQ;
                ST_DONE: nxt_d.state = ST_DONE;
                default: nxt_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_IDLE;
            cur_q.en    <= 1'b0;
            cur_q.beat  <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign dreq = (cur_q.state == ST_REQ);
    assign done = (cur_q.state == ST_DONE);

    AST_REQ_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_en) |=> dreq); // R2

    AST_SINGLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cfg_burst) |=> !dreq); // R4

    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dreq); // R9

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_en) |=> done); // R9

    AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!dreq && !done)); // R11
endmodule

// File: rtl/dma_eot_engine.sv
module dma_eot_engine #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned BURST_SHORT = 4,
    parameter int unsigned BURST_LONG  = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_cnt_en,
    input  logic             cfg_burst,
    input  logic             cfg_burst8,
    input  logic [CNT_W-1:0] xfer_bytes,
    input  logic             dack,
    input  logic             rd_stb,
    input  logic             wr_stb,
    input  logic             eot_in,
    output logic             dreq,
    output logic             done,
    output logic             buf_rd,
    output logic             buf_wr
);
    logic eot_sync, last_word, accept, clr_cnt;

    dma_eot_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (eot_in),
        .dout (eot_sync)
    );

    dma_eot_bytecnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_cnt),
        .inc      (accept),
        .cnt_en   (cfg_cnt_en),
        .limit    (xfer_bytes),
        .last_word(last_word)
    );

    dma_eot_fsm #(.BURST_SHORT(BURST_SHORT), .BURST_LONG(BURST_LONG)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_burst (cfg_burst),
        .cfg_burst8(cfg_burst8),
        .dack      (dack),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .eot_sync  (eot_sync),
        .last_word (last_word),
        .dreq      (dreq),
        .done      (done),
        .accept    (accept),
        .clr_cnt   (clr_cnt)
    );

    assign buf_rd = accept && rd_stb;
    assign buf_wr = accept && wr_stb;

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd && buf_wr)); // R3

    AST_MOVE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd || buf_wr) |-> (dack && dreq)); // R3
endmodule

// File: tb/dma_eot_engine_tb.sv
`timescale 1ns/1ps
module dma_eot_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0, cfg_cnt_en = 1'b0, cfg_burst = 1'b0, cfg_burst8 = 1'b0;
    logic [15:0] xfer_bytes = '0;
    logic        dack = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0, eot_in = 1'b0;
    logic        dreq, done, buf_rd, buf_wr;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    dma_eot_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cnt_en(cfg_cnt_en),
        .cfg_burst(cfg_burst), .cfg_burst8(cfg_burst8), .xfer_bytes(xfer_bytes),
        .dack(dack), .rd_stb(rd_stb), .wr_stb(wr_stb), .eot_in(eot_in),
        .dreq(dreq), .done(done), .buf_rd(buf_rd), .buf_wr(buf_wr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // one valid word; returns at the following negedge
    task automatic word(input bit is_wr, input string tag);
        dack = 1'b1; wr_stb = is_wr; rd_stb = !is_wr;
        #1;
        chk({tag, " R3 buf_wr"}, int'(buf_wr), int'(is_wr));
        chk({tag, " R3 buf_rd"}, int'(buf_rd), int'(!is_wr));
        step();
        dack = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0;
    endtask

    task automatic start(input bit cnt, input bit burst, input bit b8, input int bytes);
        cfg_en = 1'b0;
        step();
        cfg_cnt_en = cnt; cfg_burst = burst; cfg_burst8 = b8; xfer_bytes = 16'(bytes);
        cfg_en = 1'b1;
        step();
        chk("R2 dreq after enable", int'(dreq), 1);
    endtask

    // mode 0 single, 1 burst of 4, 2 burst of 8
    task automatic sweep_run(input int mode, input int bytes);
        int n;
        int blen;
        n    = (bytes + 1) / 2;
        blen = (mode == 0) ? 1 : ((mode == 1) ? 4 : 8);
        start(1'b1, mode != 0, mode == 2, bytes);
        for (int w = 0; w < n; w++) begin
            if (w % 3 == 1) begin
                step();
                chk("R2 dreq held while idle", int'(dreq), 1);
            end
            word(w % 2 == 0, "sweep");
            if (w == n - 1) begin
                chk("R6 done after last word", int'(done), 1);
                chk("R6 dreq low after last word", int'(dreq), 0);
            end else if ((w + 1) % blen == 0) begin
                chk(mode == 0 ? "R4 gap" : "R5 burst gap", int'(dreq), 0);
                chk("R6 no early done", int'(done), 0);
                step();
                chk(mode == 0 ? "R4 rerequest" : "R5 rerequest", int'(dreq), 1);
            end else begin
                chk("R5 dreq held in burst", int'(dreq), 1);
                chk("R6 no early done", int'(done), 0);
            end
        end
        step(); step();
        chk("R9 done held", int'(done), 1);
        chk("R9 dreq held low", int'(dreq), 0);
        cfg_en = 1'b0;
        step();
        chk("R11 done cleared", int'(done), 0);
        chk("R11 dreq low", int'(dreq), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        chk("R1 dreq in reset", int'(dreq), 0);
        chk("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        step();
        chk("R1 dreq after reset", int'(dreq), 0);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 buf_rd after reset", int'(buf_rd), 0);
        chk("R1 buf_wr after reset", int'(buf_wr), 0);

        for (int mode = 0; mode < 3; mode++)
            for (int bytes = 1; bytes <= 20; bytes++)
                sweep_run(mode, bytes);

        // R3: ignored strobes, single mode, 4 bytes
        start(1'b1, 1'b0, 1'b0, 4);
        wr_stb = 1'b1; #1;
        chk("R3 strobe without dack", int'(buf_wr), 0);
        step(); wr_stb = 1'b0;
        chk("R3 no gap without dack", int'(dreq), 1);
        dack = 1'b1; rd_stb = 1'b1; wr_stb = 1'b1; #1;
        chk("R3 both strobes rd", int'(buf_rd), 0);
        chk("R3 both strobes wr", int'(buf_wr), 0);
        step(); dack = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
        chk("R3 no gap on both strobes", int'(dreq), 1);
        word(1'b1, "R3 first");
        chk("R4 gap", int'(dreq), 0);
        dack = 1'b1; wr_stb = 1'b1; #1;
        chk("R3 strobe during gap", int'(buf_wr), 0);
        step(); dack = 1'b0; wr_stb = 1'b0;
        chk("R4 rerequest", int'(dreq), 1);
        word(1'b0, "R3 second");
        chk("R3 ignored not counted, done on 2nd word", int'(done), 1);
        cfg_en = 1'b0; step();

        // R7: re-enable restarts count, 6 bytes
        start(1'b1, 1'b0, 1'b0, 6);
        word(1'b1, "R7 a"); step();
        word(1'b1, "R7 b");
        chk("R7 not done before re-enable", int'(done), 0);
        cfg_en = 1'b0; step();
        chk("R11 dreq low on disable", int'(dreq), 0);
        cfg_en = 1'b1; step();
        chk("R7 request after re-enable", int'(dreq), 1);
        word(1'b0, "R7 c"); chk("R7 no done after 1", int'(done), 0); step();
        word(1'b0, "R7 d"); chk("R7 no done after 2", int'(done), 0); step();
        word(1'b0, "R7 e"); chk("R7 done after 3", int'(done), 1);
        cfg_en = 1'b0; step();

        // R10 + R8: counter off, external end
        start(1'b0, 1'b1, 1'b0, 2);
        for (int w = 0; w < 6; w++) begin
            word(1'b1, "R10 word");
            chk("R10 count ignored", int'(done), 0);
            if (w == 3) step();
        end
        eot_in = 1'b1;
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R8 eot ignored without dack", int'(done), 0);
            chk("R8 dreq kept without dack", int'(dreq), 1);
        end
        eot_in = 1'b0;
        step(); step(); step();
        eot_in = 1'b1; dack = 1'b1;
        step(); chk("R8 not done edge 1", int'(done), 0);
        step(); chk("R8 not done edge 2", int'(done), 0);
        step(); chk("R8 done edge 3", int'(done), 1);
        chk("R9 dreq low after eot", int'(dreq), 0);
        eot_in = 1'b0; dack = 1'b0;
        step(); step();
        chk("R9 done held after eot", int'(done), 1);
        cfg_en = 1'b0; step();
        chk("R11 done cleared", int'(done), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule